// File: doc/BRIEF.md
# Tagged Branch Target Cache

This block sits in the fetch stage and predicts where the next fetch should come from. It holds a small direct-mapped table of branch targets, looked up in the same cycle with the current fetch PC. Each entry carries a tag taken from the upper PC bits. A lookup whose tag does not match, or whose entry was never written, reports a miss and never supplies a target.

The hit and target from the table are combined with a taken/not-taken input from a separate direction predictor and with an optional corrected PC from decode. The block then produces the next fetch PC in the same cycle. When a branch resolves taken, the update port installs its tag and target in one clock.

Top module: `btac_fetch_predictor`

## Requirements
- R1: When rst_ni is asserted, every entry becomes invalid. After reset, every lookup misses until an update writes the entry.
- R2: The entry index is fetch PC bits [IDX_W+1:2], with IDX_W = log2(ENTRIES). The tag is bits [PC_W-1:IDX_W+2]. Bits [1:0] are ignored. A valid entry at the same index with a different tag reports a miss.
- R3: hit_o is 1 exactly when the indexed entry is valid and its tag matches. On a hit, pred_target_o equals the stored target; on a miss it is 0.
- R4: When redirect_valid_i is 0, hit_o is 1 and dir_taken_i is 1, next_pc_o equals the stored target.
- R5: When redirect_valid_i is 0 and there is either a miss or dir_taken_i is 0, next_pc_o equals fetch_pc_i + 4.
- R6: When redirect_valid_i is 1, next_pc_o equals redirect_pc_i, whatever the lookup and the direction input give.
- R7: An update (upd_valid_i = 1 at a rising edge) writes the valid bit, tag and target together. A lookup of the same PC in the following cycle hits with that target.
- R8: A lookup in the same cycle as an update to the same index returns the contents from before the update.
- R9: A later update to an index replaces the earlier entry, so the earlier PC then misses.
- R10: fetch_pc_i + 4 wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | PC_W | PC of the current fetch |
| dir_taken_i | input | 1 | Direction prediction, 1 = taken |
| redirect_valid_i | input | 1 | Corrected PC from decode is valid |
| redirect_pc_i | input | PC_W | Corrected PC from decode |
| upd_valid_i | input | 1 | Write a resolved taken branch |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_target_i | input | PC_W | Target of the resolved branch |
| hit_o | output | 1 | Lookup hit |
| pred_target_o | output | PC_W | Stored target on a hit, else 0 |
| next_pc_o | output | PC_W | Selected next fetch PC |

## Verification
The checker tests the next-PC priority on every cycle: redirect first, then the cached target on a taken hit, then the sequential PC. It also checks that a PC written in one cycle hits with its target when looked up in the next cycle. Several behaviours need set-up sequences that only the bench scenarios provide. These are tag-mismatch misses on an aliased index, the cleared state after reset, the return of old contents during a same-cycle write, the replacement of an entry by a later update, and the wrap of the sequential PC.

// File: rtl/btac_pkg.sv
package btac_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,
    NPC_PRED  = 2'd1,
    NPC_REDIR = 2'd2
  } npc_sel_e;
endpackage

// File: rtl/btac_addr_split.sv
module btac_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  logic unused_byte_bits;

  assign idx_o = pc_i[IDX_W+1:2];
  assign tag_o = pc_i[PC_W-1:IDX_W+2];
  assign unused_byte_bits = ^pc_i[1:0];
endmodule

// File: rtl/btac_store.sv
module btac_store #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = PC_W - IDX_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  output logic [PC_W-1:0]  target_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_target_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [PC_W-1:0]    target_q [ENTRIES];
  logic [ENTRIES-1:0] wr_sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign wr_sel[e] = wr_en_i && (wr_idx_i == IDX_W'(e));

    // only the valid bit needs reset; payload is qualified by it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        valid_q[e] <= 1'b0;
      else if (wr_sel[e]) valid_q[e] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_sel[e]) begin
        tag_q[e]    <= wr_tag_i;
        target_q[e] <= wr_target_i;
      end
    end
  end

  // read sees pre-write contents when indices collide
  always_comb begin
    hit_o    = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
    target_o = hit_o ? target_q[rd_idx_i] : '0;
  end
endmodule

// File: rtl/btac_next_pc.sv
module btac_next_pc
  import btac_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            hit_i,
  input  logic            taken_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            redir_valid_i,
  input  logic [PC_W-1:0] redir_pc_i,
  output logic [PC_W-1:0] next_pc_o
);
  npc_sel_e        sel;
  logic [PC_W-1:0] seq_pc;

  assign seq_pc = pc_i + PC_W'(4);

  always_comb begin
    if (redir_valid_i)         sel = NPC_REDIR;
    else if (hit_i && taken_i) sel = NPC_PRED;
    else                       sel = NPC_SEQ;
  end

  always_comb begin
    unique case (sel)
      NPC_REDIR: next_pc_o = redir_pc_i;
      NPC_PRED:  next_pc_o = target_i;
      default:   next_pc_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/btac_fetch_predictor.sv
module btac_fetch_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            dir_taken_i,
  input  logic            redirect_valid_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i,
  output logic            hit_o,
  output logic [PC_W-1:0] pred_target_o,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  btac_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_rd_split (
    .pc_i (fetch_pc_i),
    .idx_o(rd_idx),
    .tag_o(rd_tag)
  );

  btac_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_wr_split (
    .pc_i (upd_pc_i),
    .idx_o(wr_idx),
    .tag_o(wr_tag)
  );

  btac_store #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_tag_i   (rd_tag),
    .hit_o      (hit_o),
    .target_o   (pred_target_o),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_tag_i   (wr_tag),
    .wr_target_i(upd_target_i)
  );

  btac_next_pc #(.PC_W(PC_W)) u_next_pc (
    .pc_i         (fetch_pc_i),
    .hit_i        (hit_o),
    .taken_i      (dir_taken_i),
    .target_i     (pred_target_o),
    .redir_valid_i(redirect_valid_i),
    .redir_pc_i   (redirect_pc_i),
    .next_pc_o    (next_pc_o)
  );
endmodule

// File: rtl/btac_fetch_predictor_chk.sv
module btac_fetch_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            dir_taken_i,
  input logic            redirect_valid_i,
  input logic [PC_W-1:0] redirect_pc_i,
  input logic            upd_valid_i,
  input logic [PC_W-1:0] upd_pc_i,
  input logic [PC_W-1:0] upd_target_i,
  input logic            hit_o,
  input logic [PC_W-1:0] pred_target_o,
  input logic [PC_W-1:0] next_pc_o
);
  // R6
  redirect_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_i |-> next_pc_o == redirect_pc_i);

  // R4
  taken_hit_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_valid_i && hit_o && dir_taken_i) |-> next_pc_o == pred_target_o);

  // R5
  sequential_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_valid_i && !(hit_o && dir_taken_i)) |-> next_pc_o == fetch_pc_i + PC_W'(4));

  // R7
  update_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i) && fetch_pc_i[PC_W-1:2] == $past(upd_pc_i[PC_W-1:2]))
      |-> (hit_o && pred_target_o == $past(upd_target_i)));

  // R3
  miss_zero_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> pred_target_o == '0);
endmodule

bind btac_fetch_predictor btac_fetch_predictor_chk #(.PC_W(PC_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fetch_pc_i      (fetch_pc_i),
  .dir_taken_i     (dir_taken_i),
  .redirect_valid_i(redirect_valid_i),
  .redirect_pc_i   (redirect_pc_i),
  .upd_valid_i     (upd_valid_i),
  .upd_pc_i        (upd_pc_i),
  .upd_target_i    (upd_target_i),
  .hit_o           (hit_o),
  .pred_target_o   (pred_target_o),
  .next_pc_o       (next_pc_o)
);

// File: tb/btac_fetch_predictor_tb.sv
module btac_fetch_predictor_tb;
  localparam int PC_W = 32;

  typedef struct packed {
    logic [31:0] pc;
    logic        taken;
    logic        rv;
    logic [31:0] rpc;
    logic        exp_hit;
    logic [31:0] exp_next;
  } vec_t;

  // entries installed: 0x1010 -> 0x2000 (idx 4), 0x0104 -> 0x0040 (idx 1)
  localparam vec_t VECS [8] = '{
    '{32'h0000_1010, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_2000},  // R4
    '{32'h0000_1010, 1'b0, 1'b0, 32'h0, 1'b1, 32'h0000_1014},  // R5
    '{32'h0000_1050, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_1054},  // R2 tag mismatch
    '{32'h0000_0104, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_0040},  // R4
    '{32'h0000_0108, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0000_010C},  // R5 empty idx
    '{32'h0000_1010, 1'b1, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_3000},  // R6
    '{32'h0000_0500, 1'b0, 1'b1, 32'h0000_0700, 1'b0, 32'h0000_0700},  // R6
    '{32'h0000_1012, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_2000}   // R2 low bits
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [PC_W-1:0] fetch_pc_i = '0;
  logic            dir_taken_i = 1'b0;
  logic            redirect_valid_i = 1'b0;
  logic [PC_W-1:0] redirect_pc_i = '0;
  logic            upd_valid_i = 1'b0;
  logic [PC_W-1:0] upd_pc_i = '0;
  logic [PC_W-1:0] upd_target_i = '0;
  logic            hit_o;
  logic [PC_W-1:0] pred_target_o;
  logic [PC_W-1:0] next_pc_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  btac_fetch_predictor #(.PC_W(PC_W), .ENTRIES(16)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic tk, input logic rv, input logic [31:0] rpc);
    @(negedge clk_i);
    fetch_pc_i = pc; dir_taken_i = tk; redirect_valid_i = rv; redirect_pc_i = rpc;
    #2;
  endtask

  task automatic write_entry(input logic [31:0] pc, input logic [31:0] tgt);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_target_i = tgt;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty after reset
    lookup(32'h0000_1010, 1'b1, 1'b0, 32'h0);
    check("R1 hit", {31'b0, hit_o}, 32'd0);
    check("R1 next", next_pc_o, 32'h0000_1014);

    write_entry(32'h0000_1010, 32'h0000_2000);
    write_entry(32'h0000_0104, 32'h0000_0040);

    foreach (VECS[i]) begin
      lookup(VECS[i].pc, VECS[i].taken, VECS[i].rv, VECS[i].rpc);
      check($sformatf("R3 vec%0d hit", i), {31'b0, hit_o}, {31'b0, VECS[i].exp_hit});
      check($sformatf("R4/R5/R6 vec%0d next", i), next_pc_o, VECS[i].exp_next);
    end

    // R3: miss target is zero
    lookup(32'h0000_1050, 1'b1, 1'b0, 32'h0);
    check("R3 miss target", pred_target_o, 32'h0);

    // R8: same-cycle write and read of idx 2 returns old (empty) contents
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = 32'h0000_0208; upd_target_i = 32'h0000_0900;
    fetch_pc_i = 32'h0000_0208; dir_taken_i = 1'b1; redirect_valid_i = 1'b0;
    #2;
    check("R8 old hit", {31'b0, hit_o}, 32'd0);
    check("R8 old next", next_pc_o, 32'h0000_020C);
    // R7: visible next cycle
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #2;
    check("R7 hit", {31'b0, hit_o}, 32'd1);
    check("R7 target", pred_target_o, 32'h0000_0900);

    // R9: aliased update replaces entry at idx 4
    write_entry(32'h0000_1050, 32'h0000_5000);
    lookup(32'h0000_1010, 1'b1, 1'b0, 32'h0);
    check("R9 old pc misses", {31'b0, hit_o}, 32'd0);
    lookup(32'h0000_1050, 1'b1, 1'b0, 32'h0);
    check("R9 new pc next", next_pc_o, 32'h0000_5000);

    // R10: sequential wrap
    lookup(32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0);
    check("R10 wrap", next_pc_o, 32'h0000_0000);

    // R1: reset mid-run clears entries
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    lookup(32'h0000_0104, 1'b1, 1'b0, 32'h0);
    check("R1 cleared hit", {31'b0, hit_o}, 32'd0);
    check("R1 cleared next", next_pc_o, 32'h0000_0108);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule